// File: doc/BRIEF.md
# NAND Page Read Command Sequencer

This block starts a page read on a NAND flash device by pushing a short series of bytes into a byte-wide write port. Each byte carries one of two qualifiers. The command qualifier marks a byte that the device should latch as an opcode. The address qualifier marks a byte that the device should latch as part of the start address. Whatever sits behind the port turns each accepted byte into one write strobe and drives the two qualifiers onto the device's latch-enable pins.

A request carries a start address and a mode bit. The mode bit picks the long form, which has four address cycles, or the short form, which has three. The block first sends the read opcode, but only if the device does not already hold it. It then sends the address bytes, lowest first. Bit 8 of the start address is never sent, because it selects the half of the page and is not given to the device. A one-cycle done pulse follows the last address byte.

The block keeps a flag that records that the read opcode is latched. The flag lets back-to-back page reads skip the opcode cycle. A separate clear input drops the flag once other traffic has reached the device.

Top module: `nand_rdseq_top`

## Requirements
- R1: After reset the write port is idle (`wr_valid_o`, `wr_cle_o`, `wr_ale_o`, `done_o`, `busy_o` all 0), and the command-latched flag is clear.
- R2: When a request is accepted with the flag clear, the first byte sent is the read opcode 0x00, with `wr_cle_o`=1 and `wr_ale_o`=0. Accepting that byte sets the flag.
- R3: When a request is accepted with the flag set, no opcode byte is sent, and the first byte is address byte 0.
- R4: Address bytes are sent with `wr_ale_o`=1 and `wr_cle_o`=0, in this order: byte 0 = A[7:0], byte 1 = A[16:9], byte 2 = A[24:17].
- R5: With `long_addr_i`=1 a fourth byte follows, equal to {7'b0, A[25]} (A[25] in bit 0). With `long_addr_i`=0 the sequence ends after byte 2.
- R6: Bit 8 of the start address has no effect on any byte sent.
- R7: A byte is transferred only in a cycle where `wr_valid_o` and `wr_ready_i` are both 1. While `wr_valid_o`=1 and `wr_ready_i`=0, the data and both qualifiers are held, and the next byte is not presented until the current one is accepted.
- R8: `clr_latched_i`=1 clears the flag, and the next request sends the opcode again. If a clear and an opcode acceptance fall in the same cycle, the clear wins.
- R9: `done_o` is high for exactly one cycle: the cycle after the last address byte is accepted.
- R10: `start_i` has no effect while `busy_o`=1. No extra bytes are produced, and the running sequence keeps its captured address.
- R11: `wr_cle_o` and `wr_ale_o` are never high together, and both are low while `wr_valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| start_addr_i | input | ADDR_W | Start address of the page read |
| long_addr_i | input | 1 | 1 = four address cycles, 0 = three |
| clr_latched_i | input | 1 | Clears the command-latched flag |
| wr_valid_o | output | 1 | A byte is offered on the write port |
| wr_ready_i | input | 1 | The write port accepts the offered byte |
| wr_data_o | output | 8 | Byte value |
| wr_cle_o | output | 1 | Command qualifier for the offered byte |
| wr_ale_o | output | 1 | Address qualifier for the offered byte |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse after the final address byte |

## Verification
The bench builds the block with its default parameters: a 26-bit address, four address cycles at most, and opcode 0x00. These values reach every address bit, including the bit-25 byte and the skipped bit 8. The write port's ready signal runs in three patterns: always ready, pseudo-random stalls, and held low. Together these cover back-pressure at every byte position. Holding ready low keeps a sequence busy long enough to fire a stray start into it. Sequences run back to back, in both address lengths, with the flag cleared in between and left set.

// File: rtl/nrd_pkg.sv
`timescale 1ns/1ps
package nrd_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_ADDR = 2'd2
  } nrd_state_e;
endpackage

// File: rtl/nrd_rst_sync.sv
`timescale 1ns/1ps
module nrd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/nrd_addr_split.sv
`timescale 1ns/1ps
module nrd_addr_split
  import nrd_pkg::*;
#(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned NCYC   = 4,
  localparam int unsigned IDX_W = (NCYC > 1) ? $clog2(NCYC) : 1,
  localparam int unsigned PAD_W = BYTE_W * NCYC + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [PAD_W-1:0] padded;
  logic [NCYC-1:0][BYTE_W-1:0] lanes;
  logic unused_gap;

  assign padded = {{(PAD_W-ADDR_W){1'b0}}, addr_i};
  // Bit 8 (page half select) is never sent.
  assign unused_gap = padded[BYTE_W];

  genvar k;
  generate
    for (k = 0; k < NCYC; k++) begin : g_lane
      if (k == 0) begin : g_low
        assign lanes[k] = padded[BYTE_W-1:0];
      end else begin : g_high
        assign lanes[k] = padded[BYTE_W*k+1 +: BYTE_W];
      end
    end
  endgenerate

  always_comb begin
    byte_o = lanes[idx_i];
  end
endmodule

// File: rtl/nrd_cmd_flag.sv
`timescale 1ns/1ps
module nrd_cmd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic latched_o
);
  logic latched_q;
  logic latched_d;

  always_comb begin
    latched_d = latched_q;
    if (set_i) latched_d = 1'b1;
    if (clr_i) latched_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latched_q <= 1'b0;
    else        latched_q <= latched_d;
  end

  assign latched_o = latched_q;

  // R3
  keep_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latched_q && !clr_i |=> latched_q);

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !latched_q);
endmodule

// File: rtl/nrd_seq_fsm.sv
`timescale 1ns/1ps
module nrd_seq_fsm
  import nrd_pkg::*;
#(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned NCYC   = 4,
  localparam int unsigned IDX_W = (NCYC > 1) ? $clog2(NCYC) : 1,
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(NCYC - 1),
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(NCYC - 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              long_i,
  input  logic              latched_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cmd_acc_o,
  output logic              busy_o,
  output logic              done_o
);
  nrd_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q;
  logic              long_q;
  logic              done_q, done_d;
  logic              take;
  logic              accept;
  logic              last_byte;

  assign take      = (state_q == ST_IDLE) && start_i;
  assign accept    = (state_q != ST_IDLE) && ready_i;
  assign last_byte = (idx_q == (long_q ? LAST_LONG : LAST_SHORT));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          idx_d   = '0;
          state_d = latched_i ? ST_ADDR : ST_CMD;
        end
      end
      ST_CMD: begin
        if (accept) begin
          idx_d   = '0;
          state_d = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (accept) begin
          if (last_byte) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  // Capture registers, clock-enabled by an accepted request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      long_q <= 1'b0;
    end else if (take) begin
      addr_q <= addr_i;
      long_q <= long_i;
    end
  end

  assign valid_o   = (state_q != ST_IDLE);
  assign cle_o     = (state_q == ST_CMD);
  assign ale_o     = (state_q == ST_ADDR);
  assign idx_o     = idx_q;
  assign addr_o    = addr_q;
  assign cmd_acc_o = (state_q == ST_CMD) && ready_i;
  assign busy_o    = valid_o;
  assign done_o    = done_q;

  // R7
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(idx_q) && $stable(cle_o) && $stable(ale_o));

  // R2
  cmd_then_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cle_o && ready_i |=> ale_o && idx_q == '0);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !valid_o);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && start_i |=> $stable(addr_q) && $stable(long_q));

  // R11
  qual_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle_o && ale_o) && (valid_o || (!cle_o && !ale_o)));
endmodule

// File: rtl/nand_rdseq_top.sv
`timescale 1ns/1ps
module nand_rdseq_top
  import nrd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 26,
  parameter int unsigned NCYC     = 4,
  parameter logic [7:0]  READ_CMD = 8'h00,
  localparam int unsigned IDX_W   = (NCYC > 1) ? $clog2(NCYC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              long_addr_i,
  input  logic              clr_latched_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [7:0]        wr_data_o,
  output logic              wr_cle_o,
  output logic              wr_ale_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              rst_sync_n;
  logic              latched;
  logic              cmd_acc;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr_cap;
  logic [BYTE_W-1:0] addr_byte;
  logic              cle;

  nrd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nrd_cmd_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_i     (cmd_acc),
    .clr_i     (clr_latched_i),
    .latched_o (latched)
  );

  nrd_seq_fsm #(.ADDR_W(ADDR_W), .NCYC(NCYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start_i),
    .addr_i    (start_addr_i),
    .long_i    (long_addr_i),
    .latched_i (latched),
    .ready_i   (wr_ready_i),
    .valid_o   (wr_valid_o),
    .cle_o     (cle),
    .ale_o     (wr_ale_o),
    .idx_o     (idx),
    .addr_o    (addr_cap),
    .cmd_acc_o (cmd_acc),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  nrd_addr_split #(.ADDR_W(ADDR_W), .NCYC(NCYC)) u_split (
    .addr_i (addr_cap),
    .idx_i  (idx),
    .byte_o (addr_byte)
  );

  assign wr_cle_o  = cle;
  assign wr_data_o = cle ? READ_CMD : addr_byte;
endmodule

// File: tb/test_nand_rdseq_top.sv
`timescale 1ns/1ps
module test_nand_rdseq_top;
  localparam int ADDR_W = 26;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, long_addr_i, clr_latched_i, wr_ready_i;
  logic [ADDR_W-1:0] start_addr_i;
  logic wr_valid_o, wr_cle_o, wr_ale_o, busy_o, done_o;
  logic [7:0] wr_data_o;

  always #2.5 clk = ~clk;

  nand_rdseq_top i_nand_rdseq_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .long_addr_i(long_addr_i), .clr_latched_i(clr_latched_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_data_o(wr_data_o),
    .wr_cle_o(wr_cle_o), .wr_ale_o(wr_ale_o), .busy_o(busy_o), .done_o(done_o)
  );

  int tests = 0;
  int fails = 0;
  logic [10:0] exp_q[$];   // {last, cle, ale, data}
  bit model_latched = 0;
  bit pend_done = 0;
  bit mon_on = 0;
  int rmode = 0;           // 0 always ready, 1 random stalls, 2 held low
  logic [15:0] lfsr = 16'hACE1;
  bit hold_pend = 0;
  logic [9:0] hold_val;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [ADDR_W-1:0] a, input int k);
    case (k)
      0: return a[7:0];
      1: return a[16:9];
      2: return a[24:17];
      default: return {7'b0, a[25]};
    endcase
  endfunction

  // ready driver
  initial begin
    wr_ready_i = 1'b0;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr_ready_i = (rmode == 0) ? 1'b1 : (rmode == 1) ? lfsr[0] : 1'b0;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (pend_done) begin
        chk(done_o === 1'b1, "R9 done after last byte", done_o, 1);
        pend_done = 0;
      end else if (done_o !== 1'b0) begin
        chk(0, "R9 unexpected done", done_o, 0);
      end
      if (hold_pend) begin
        chk(wr_valid_o && {wr_cle_o, wr_ale_o, wr_data_o} == hold_val,
            "R7 byte held under stall", {wr_valid_o, wr_cle_o, wr_ale_o, wr_data_o},
            {1'b1, hold_val});
        hold_pend = 0;
      end
      if (!wr_valid_o && (wr_cle_o || wr_ale_o))
        chk(0, "R11 qualifier while idle", {wr_cle_o, wr_ale_o}, 0);
      if (wr_valid_o && !wr_ready_i) begin
        hold_pend = 1;
        hold_val = {wr_cle_o, wr_ale_o, wr_data_o};
      end
      if (wr_valid_o && wr_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10/R3 unexpected byte", {wr_cle_o, wr_ale_o, wr_data_o}, 0);
        end else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          // R2 R4 R5 R6 R11: byte value and qualifiers
          chk({wr_cle_o, wr_ale_o, wr_data_o} == e[9:0] && !(wr_cle_o && wr_ale_o),
              e[9] ? "R2 opcode byte" : "R4/R5/R6 address byte",
              {wr_cle_o, wr_ale_o, wr_data_o}, e[9:0]);
          if (e[10]) pend_done = 1;
        end
      end
    end
  end

  task automatic issue(input logic [ADDR_W-1:0] a, input bit lng);
    int n;
    if (!model_latched) begin
      exp_q.push_back({1'b0, 1'b1, 1'b0, 8'h00});
      model_latched = 1;
    end
    n = lng ? 4 : 3;
    for (int k = 0; k < n; k++)
      exp_q.push_back({(k == n - 1), 1'b0, 1'b1, exp_byte(a, k)});
    @(posedge clk); #1;
    start_i = 1; start_addr_i = a; long_addr_i = lng;
    @(posedge clk); #1;
    start_i = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (exp_q.size() != 0 || pend_done || busy_o);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(posedge clk); #1; clr_latched_i = 1;
    @(posedge clk); #1; clr_latched_i = 0;
    model_latched = 0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; start_i = 0; long_addr_i = 0; clr_latched_i = 0; start_addr_i = '0;
    repeat (4) @(posedge clk); #1;
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!wr_valid_o && !wr_cle_o && !wr_ale_o && !done_o && !busy_o, "R1 idle after reset",
        {wr_valid_o, wr_cle_o, wr_ale_o, done_o, busy_o}, 0);
    mon_on = 1;

    // R1 R2 R4 R5: first read sends opcode, four address bytes
    issue(26'h2AB_CDEF, 1); wait_idle();
    // R3: opcode skipped
    issue(26'h135_7913, 1); wait_idle();
    // R5: three-cycle form
    issue(26'h3FF_00FF, 0); wait_idle();
    // R6: bit 8 toggled, same bytes expected
    issue(26'h012_3456 | 26'h100, 1); wait_idle();
    issue(26'h012_3456 & ~26'h100, 1); wait_idle();
    issue(26'h3FF_FFFF, 1); wait_idle();
    issue(26'h000_0000, 0); wait_idle();

    // R7: random back-pressure
    rmode = 1;
    for (int i = 0; i < 12; i++) begin
      issue({lfsr[9:0], lfsr}, i[0]);
      wait_idle();
    end
    // R8: clear then opcode resent, under stalls
    clear_flag();
    issue(26'h2DE_AD01, 1); wait_idle();
    issue(26'h1BE_EF02, 0); wait_idle();
    rmode = 0;
    clear_flag();
    issue(26'h0C0_FFEE, 0); wait_idle();

    // R10: start while busy is ignored
    rmode = 2;
    issue(26'h155_5555, 1);
    repeat (3) @(posedge clk); #1;
    start_i = 1; start_addr_i = 26'h2AA_AAAA; long_addr_i = 0;
    @(posedge clk); #1; start_i = 0;
    @(negedge clk);
    chk(busy_o === 1'b1, "R10 still busy under held-low ready", busy_o, 1);
    rmode = 0;
    wait_idle();
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0 && !busy_o, "R10 no extra bytes", exp_q.size(), 0);

    mon_on = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule